// File: doc/BRIEF.md
# Data Access Breakpoint and Alignment Checker

This block sits beside the load/store unit of a core and inspects every data access as it is issued. Each access brings an address and a flag that tells a store from a load. The block first relocates the address into the current process slot: a nonzero process tag is ORed into the top address bits when those bits are all zero. It then tests the relocated address for word alignment and compares it against two programmable data breakpoints. The outcome comes back one cycle later as single-cycle abort and breakpoint pulses.

Configuration is written through a simple register write port and can be read back through a combinational read port. Both ports use the same 3-bit register select. An alignment fault loads the fault status and fault address registers. A breakpoint hit records an entry code in the debug status register when debug is enabled. Faults reported by other units can also load the fault registers, but only while debug is enabled. What the core does after a request is outside this block.

The result of each access is held in a four-state outcome machine. `ST_CLEAR` means nothing is raised, `ST_ABORT` means misalignment only, `ST_BREAK` means a breakpoint hit only, and `ST_BOTH` means both. Every clock the machine moves to the state that the current access selects. With no access, or an access that raises nothing, it moves to `ST_CLEAR`. A misaligned access goes to `ST_ABORT`, a breakpoint hit to `ST_BREAK`, and an access that does both to `ST_BOTH`. No state is sticky.

Top module: `dabk_unit`

## Requirements
- R1: After reset all eight registers read zero and `abort_o` and `bkpt_o` are low.
- R2: Select 0 holds the process tag in bits 31:25. When the tag is nonzero and `acc_addr[31:25]` is zero, `xlat_addr` equals `acc_addr` with the tag ORed into bits 31:25. Otherwise `xlat_addr` equals `acc_addr`. The breakpoint and alignment checks use `xlat_addr`, and `xlat_addr` bits 24:0 always equal `acc_addr` bits 24:0.
- R3: Bit 1 of select 1 enables alignment checking. While it is set, an access whose `xlat_addr[1:0]` is nonzero makes `abort_o` high in the cycle after the access. In that cycle, fault status (select 6) reads the alignment code 0x001 and fault address (select 7) reads `xlat_addr`. While the bit is clear, misalignment has no effect.
- R4: Breakpoint control (select 4) gives enable field E0 at bits 1:0 for breakpoint 0 and E1 at bits 3:2 for breakpoint 1. Each field reads 0 = off, 1 = stores only, 2 = loads and stores, 3 = loads only.
- R5: With control bit 8 clear, breakpoint 0 hits when `xlat_addr[31:2]` equals bits 31:2 of select 2. Breakpoint 1 hits when `xlat_addr[31:2]` equals bits 31:2 of select 3. Each is qualified by its own enable field.
- R6: With control bit 8 set, only E0 is used, and the hit condition is (addr & ~sel3) == (sel2 & ~sel3). E1 has no effect in this mode.
- R7: Any hit makes `bkpt_o` high in the cycle after the access. If debug status (select 5) bit 31 is set, bits 4:2 of debug status then read 3'b010. If bit 31 is clear, debug status is unchanged.
- R8: A pulse on `ext_flt_valid` loads fault status with `ext_flt_status` masked to bits 10:9 and 7:0, and loads fault address with `ext_flt_addr`, only while debug status bit 31 is set. While bit 31 is clear, both registers are unchanged. An alignment fault in the same cycle takes priority.
- R9: Port writes keep only the defined bits: process tag 31:25, system control bit 1, control bits 8 and 3:0, debug status bits 31 and 4:2, fault status bits 10:9 and 7:0. The breakpoint and fault address registers keep all bits. Updates caused by accesses take priority over a port write in the same cycle.
- R10: `abort_o` and `bkpt_o` are high only in the cycle directly after an access that raised them. After a cycle without an access, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A data access is presented this cycle |
| acc_addr | input | 32 | Access address before relocation |
| acc_store | input | 1 | 1 = store, 0 = load |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 32 | Register write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 32 | Selected register contents |
| ext_flt_valid | input | 1 | External fault report strobe |
| ext_flt_status | input | 32 | External fault status value |
| ext_flt_addr | input | 32 | External fault address |
| xlat_addr | output | 32 | Relocated access address |
| abort_o | output | 1 | Alignment abort pulse |
| bkpt_o | output | 1 | Data breakpoint request pulse |

## Verification
The embedded assertions check properties on every cycle. Each pulse must trace back to an access in the previous cycle. The low address bits must pass through relocation untouched. An alignment abort must leave the alignment code in fault status. A hit with debug enabled must leave the entry code in debug status. An external fault must not disturb fault status while debug is disabled. Other behaviour can only be shown by the bench's scenarios. These are the load/store qualification of each enable code, the exact address compare in normal and mask mode, and the fact that E1 is ignored in mask mode. They also cover relocation feeding both the comparators and the fault address, and the write masks of each register.

// File: rtl/dabk_pkg.sv
`timescale 1ns/1ps
package dabk_pkg;
    localparam int NREG  = 8;
    localparam int SEL_W = $clog2(NREG);

    typedef enum logic [SEL_W-1:0] {
        SEL_PID    = 3'd0,
        SEL_SYSCTL = 3'd1,
        SEL_BPA0   = 3'd2,
        SEL_BPA1   = 3'd3,
        SEL_BPCTL  = 3'd4,
        SEL_DSTAT  = 3'd5,
        SEL_FSTAT  = 3'd6,
        SEL_FADDR  = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_ABORT = 2'd1,
        ST_BREAK = 2'd2,
        ST_BOTH  = 2'd3
    } outcome_e;

    localparam logic [2:0] MOE_DATA_BP = 3'b010;
    localparam int         BP_COUNT    = 2;
    localparam int         EN_W        = 2;
endpackage

// File: rtl/dabk_reloc.sv
`timescale 1ns/1ps
module dabk_reloc #(
    parameter int ADDR_W = 32,
    parameter int PID_W  = 7
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [PID_W-1:0]  pid_tag,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int LO_W = ADDR_W - PID_W;

    logic top_zero;
    logic tag_live;

    always_comb begin
        top_zero = (addr_in[ADDR_W-1 -: PID_W] == '0);
        tag_live = (pid_tag != '0);
        addr_out = addr_in;
        if (top_zero && tag_live) begin
            addr_out[ADDR_W-1 -: PID_W] = pid_tag;
        end
        addr_out[LO_W-1:0] = addr_in[LO_W-1:0];
    end
endmodule

// File: rtl/dabk_bpmatch.sv
`timescale 1ns/1ps
module dabk_bpmatch
    import dabk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     is_store,
    input  logic [ADDR_W-1:0]        bpa0,
    input  logic [ADDR_W-1:0]        bpa1,
    input  logic [BP_COUNT*EN_W-1:0] bp_en,
    input  logic                     mask_mode,
    output logic                     hit
);
    localparam int CMP_LO = 2;

    function automatic logic type_ok(input logic [EN_W-1:0] en, input logic st);
        logic ok;
        unique case (en)
            2'd0:    ok = 1'b0;
            2'd1:    ok = st;
            2'd2:    ok = 1'b1;
            default: ok = !st;
        endcase
        return ok;
    endfunction

    logic [ADDR_W-1:0] bases [BP_COUNT];
    logic [BP_COUNT-1:0] slot_hit;
    logic mask_hit;

    assign bases[0] = bpa0;
    assign bases[1] = bpa1;

    genvar g;
    generate
        for (g = 0; g < BP_COUNT; g++) begin : g_slot
            logic en_ok;
            logic addr_eq;
            assign en_ok   = type_ok(bp_en[g*EN_W +: EN_W], is_store);
            assign addr_eq = (addr[ADDR_W-1:CMP_LO] == bases[g][ADDR_W-1:CMP_LO]);
            assign slot_hit[g] = en_ok && addr_eq;
        end
    endgenerate

    always_comb begin
        mask_hit = type_ok(bp_en[EN_W-1:0], is_store)
                   && ((addr & ~bpa1) == (bpa0 & ~bpa1));
        hit = mask_mode ? mask_hit : (|slot_hit);
    end
endmodule

// File: rtl/dabk_regs.sv
`timescale 1ns/1ps
module dabk_regs
    import dabk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PID_W  = 7,
    parameter logic [ADDR_W-1:0] FSR_ALIGN_CODE = 'h1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         wr_sel,
    input  logic [ADDR_W-1:0]        wr_data,
    input  logic [SEL_W-1:0]         rd_sel,
    output logic [ADDR_W-1:0]        rd_data,
    input  logic                     align_flt,
    input  logic [ADDR_W-1:0]        align_addr,
    input  logic                     bp_hit,
    input  logic                     ext_flt_valid,
    input  logic [ADDR_W-1:0]        ext_flt_status,
    input  logic [ADDR_W-1:0]        ext_flt_addr,
    output logic [PID_W-1:0]         pid,
    output logic                     align_en,
    output logic [ADDR_W-1:0]        bpa0,
    output logic [ADDR_W-1:0]        bpa1,
    output logic [BP_COUNT*EN_W-1:0] bp_en,
    output logic                     bp_mask_mode,
    output logic                     dbg_en,
    output logic [2:0]               dbg_moe
);
    localparam int MASK_BIT = 8;
    localparam logic [ADDR_W-1:0] PID_MASK = {{PID_W{1'b1}}, {(ADDR_W-PID_W){1'b0}}};
    localparam logic [ADDR_W-1:0] SYS_MASK = ADDR_W'('h2);
    localparam logic [ADDR_W-1:0] CTL_MASK = ADDR_W'('h10F);
    localparam logic [ADDR_W-1:0] DST_MASK = {1'b1, (ADDR_W-1)'('h1C)};
    localparam logic [ADDR_W-1:0] FSR_MASK = ADDR_W'('h6FF);
    localparam logic [ADDR_W-1:0] ALL_MASK = '1;

    function automatic logic [ADDR_W-1:0] wmask(input int idx);
        logic [ADDR_W-1:0] m;
        case (idx)
            0:       m = PID_MASK;
            1:       m = SYS_MASK;
            4:       m = CTL_MASK;
            5:       m = DST_MASK;
            6:       m = FSR_MASK;
            default: m = ALL_MASK;
        endcase
        return m;
    endfunction

    logic [ADDR_W-1:0] regs_q [NREG];
    logic              hw_we  [NREG];
    logic [ADDR_W-1:0] hw_val [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            hw_we[i]  = 1'b0;
            hw_val[i] = regs_q[i];
        end
        if (align_flt) begin
            hw_we[SEL_FSTAT]  = 1'b1;
            hw_val[SEL_FSTAT] = FSR_ALIGN_CODE & FSR_MASK;
            hw_we[SEL_FADDR]  = 1'b1;
            hw_val[SEL_FADDR] = align_addr;
        end else if (ext_flt_valid && dbg_en) begin
            hw_we[SEL_FSTAT]  = 1'b1;
            hw_val[SEL_FSTAT] = ext_flt_status & FSR_MASK;
            hw_we[SEL_FADDR]  = 1'b1;
            hw_val[SEL_FADDR] = ext_flt_addr;
        end
        if (bp_hit && dbg_en) begin
            hw_we[SEL_DSTAT]       = 1'b1;
            hw_val[SEL_DSTAT][4:2] = MOE_DATA_BP;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_reg
            localparam logic [ADDR_W-1:0] WM = wmask(g);
            logic [ADDR_W-1:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (hw_we[g]) begin
                    q <= hw_val[g];
                end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                    q <= wr_data & WM;
                end
            end
            assign regs_q[g] = q;
        end
    endgenerate

    assign rd_data      = regs_q[rd_sel];
    assign pid          = regs_q[SEL_PID][ADDR_W-1 -: PID_W];
    assign align_en     = regs_q[SEL_SYSCTL][1];
    assign bpa0         = regs_q[SEL_BPA0];
    assign bpa1         = regs_q[SEL_BPA1];
    assign bp_en        = regs_q[SEL_BPCTL][BP_COUNT*EN_W-1:0];
    assign bp_mask_mode = regs_q[SEL_BPCTL][MASK_BIT];
    assign dbg_en       = regs_q[SEL_DSTAT][ADDR_W-1];
    assign dbg_moe      = regs_q[SEL_DSTAT][4:2];

    // External reports leave fault status alone while debug is off
    assert_ext_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_flt_valid && !dbg_en && !align_flt && !(wr_en && wr_sel == SEL_W'(SEL_FSTAT)))
        |=> $stable(regs_q[SEL_FSTAT]));

    // An alignment fault always lands the alignment code
    assert_align_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        align_flt |=> (regs_q[SEL_FSTAT] == (FSR_ALIGN_CODE & FSR_MASK)));
endmodule

// File: rtl/dabk_unit.sv
`timescale 1ns/1ps
module dabk_unit
    import dabk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PID_W  = 7,
    parameter logic [ADDR_W-1:0] FSR_ALIGN_CODE = 'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [31:0]       acc_addr,
    input  logic              acc_store,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic [2:0]        rd_sel,
    output logic [31:0]       rd_data,
    input  logic              ext_flt_valid,
    input  logic [31:0]       ext_flt_status,
    input  logic [31:0]       ext_flt_addr,
    output logic [31:0]       xlat_addr,
    output logic              abort_o,
    output logic              bkpt_o
);
    localparam int LO_W = ADDR_W - PID_W;

    logic [PID_W-1:0]         pid;
    logic                     align_en;
    logic [ADDR_W-1:0]        bpa0;
    logic [ADDR_W-1:0]        bpa1;
    logic [BP_COUNT*EN_W-1:0] bp_en;
    logic                     bp_mask_mode;
    logic                     dbg_en;
    logic [2:0]               dbg_moe;
    logic                     raw_hit;
    logic                     misalign;
    logic                     hit;

    outcome_e state_q;
    outcome_e state_d;

    dabk_reloc #(.ADDR_W(ADDR_W), .PID_W(PID_W)) u_reloc (
        .addr_in  (acc_addr),
        .pid_tag  (pid),
        .addr_out (xlat_addr)
    );

    dabk_bpmatch #(.ADDR_W(ADDR_W)) u_match (
        .addr      (xlat_addr),
        .is_store  (acc_store),
        .bpa0      (bpa0),
        .bpa1      (bpa1),
        .bp_en     (bp_en),
        .mask_mode (bp_mask_mode),
        .hit       (raw_hit)
    );

    assign misalign = acc_valid && align_en && (xlat_addr[1:0] != 2'b00);
    assign hit      = acc_valid && raw_hit;

    dabk_regs #(.ADDR_W(ADDR_W), .PID_W(PID_W), .FSR_ALIGN_CODE(FSR_ALIGN_CODE)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_sel         (wr_sel),
        .wr_data        (wr_data),
        .rd_sel         (rd_sel),
        .rd_data        (rd_data),
        .align_flt      (misalign),
        .align_addr     (xlat_addr),
        .bp_hit         (hit),
        .ext_flt_valid  (ext_flt_valid),
        .ext_flt_status (ext_flt_status),
        .ext_flt_addr   (ext_flt_addr),
        .pid            (pid),
        .align_en       (align_en),
        .bpa0           (bpa0),
        .bpa1           (bpa1),
        .bp_en          (bp_en),
        .bp_mask_mode   (bp_mask_mode),
        .dbg_en         (dbg_en),
        .dbg_moe        (dbg_moe)
    );

    // Next outcome
    always_comb begin
        unique case ({misalign, hit})
            2'b00:   state_d = ST_CLEAR;
            2'b01:   state_d = ST_BREAK;
            2'b10:   state_d = ST_ABORT;
            default: state_d = ST_BOTH;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_CLEAR: begin abort_o = 1'b0; bkpt_o = 1'b0; end
            ST_ABORT: begin abort_o = 1'b1; bkpt_o = 1'b0; end
            ST_BREAK: begin abort_o = 1'b0; bkpt_o = 1'b1; end
            default:  begin abort_o = 1'b1; bkpt_o = 1'b1; end
        endcase
    end

    assert_abort_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> $past(acc_valid && align_en));

    assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!abort_o && !bkpt_o));

    assert_low_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> (xlat_addr[LO_W-1:0] == acc_addr[LO_W-1:0]));

    assert_no_reloc_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr[ADDR_W-1 -: PID_W] != '0) |-> (xlat_addr == acc_addr));

    assert_moe_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bkpt_o && dbg_en && !$past(wr_en && wr_sel == SEL_W'(SEL_DSTAT)))
        |-> (dbg_moe == MOE_DATA_BP));
endmodule

// File: tb/sim_dabk_unit.sv
`timescale 1ns/1ps
module sim_dabk_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = 32'h0;
    logic        acc_store = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [31:0] wr_data = 32'h0;
    logic [2:0]  rd_sel = 3'd0;
    logic [31:0] rd_data;
    logic        ext_flt_valid = 1'b0;
    logic [31:0] ext_flt_status = 32'h0;
    logic [31:0] ext_flt_addr = 32'h0;
    logic [31:0] xlat_addr;
    logic        abort_o;
    logic        bkpt_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dabk_unit u0 (.*);

    localparam logic [2:0] R_PID = 3'd0, R_SYS = 3'd1, R_BA0 = 3'd2, R_BA1 = 3'd3,
                           R_CTL = 3'd4, R_DST = 3'd5, R_FST = 3'd6, R_FAD = 3'd7;

    typedef struct packed {
        logic [31:0] bpa0;
        logic [31:0] bpa1;
        logic [8:0]  ctl;
        logic [31:0] addr;
        logic        st;
        logic        hit;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h1000, 32'h0,    9'h002, 32'h1000, 1'b1, 1'b1},
        '{32'h1000, 32'h0,    9'h002, 32'h1003, 1'b0, 1'b1},
        '{32'h1000, 32'h0,    9'h002, 32'h1004, 1'b0, 1'b0},
        '{32'h1000, 32'h0,    9'h001, 32'h1000, 1'b0, 1'b0},
        '{32'h1000, 32'h0,    9'h001, 32'h1000, 1'b1, 1'b1},
        '{32'h1000, 32'h0,    9'h003, 32'h1000, 1'b1, 1'b0},
        '{32'h1000, 32'h0,    9'h003, 32'h1000, 1'b0, 1'b1},
        '{32'h1000, 32'h0,    9'h000, 32'h1000, 1'b1, 1'b0},
        '{32'h0,    32'h2000, 9'h004, 32'h2002, 1'b1, 1'b1},
        '{32'h0,    32'h2000, 9'h004, 32'h2000, 1'b0, 1'b0},
        '{32'h3000, 32'h00FF, 9'h102, 32'h30A5, 1'b0, 1'b1},
        '{32'h3000, 32'h00FF, 9'h102, 32'h3100, 1'b0, 1'b0},
        '{32'h3000, 32'h00FC, 9'h10C, 32'h00FC, 1'b0, 1'b0},
        '{32'h3000, 32'h00FF, 9'h101, 32'h3001, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    // Present one access; on return the result cycle is visible
    task automatic access(input logic [31:0] a, input logic st);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_store = st;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic ext_fault(input logic [31:0] s, input logic [31:0] a);
        @(negedge clk);
        ext_flt_valid = 1'b1; ext_flt_status = s; ext_flt_addr = a;
        @(negedge clk);
        ext_flt_valid = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), v);
            chk("R1 register zero", v, 32'h0);
        end
        chk("R1 abort low", {31'h0, abort_o}, 32'h0);
        chk("R1 bkpt low", {31'h0, bkpt_o}, 32'h0);

        // R4 R5 R6 table
        for (int i = 0; i < NV; i++) begin
            wr(R_BA0, VECS[i].bpa0);
            wr(R_BA1, VECS[i].bpa1);
            wr(R_CTL, {23'h0, VECS[i].ctl});
            access(VECS[i].addr, VECS[i].st);
            chk($sformatf("R4/R5/R6 vector %0d bkpt", i), {31'h0, bkpt_o}, {31'h0, VECS[i].hit});
            chk($sformatf("R3 vector %0d no abort", i), {31'h0, abort_o}, 32'h0);
        end
        wr(R_CTL, 32'h0);

        // R2 relocation
        wr(R_PID, 32'h0A00_FFFF);
        rd(R_PID, v);
        chk("R9 pid mask", v, 32'h0A00_0000);
        @(negedge clk);
        acc_addr = 32'h0000_1234; #1;
        chk("R2 relocate", xlat_addr, 32'h0A00_1234);
        acc_addr = 32'h8000_1234; #1;
        chk("R2 high bits kept", xlat_addr, 32'h8000_1234);
        wr(R_BA0, 32'h0A00_1000);
        wr(R_CTL, 32'h2);
        access(32'h0000_1000, 1'b1);
        chk("R2 relocated compare", {31'h0, bkpt_o}, 32'h1);
        wr(R_CTL, 32'h0);
        wr(R_PID, 32'h0);

        // R3 alignment
        wr(R_SYS, 32'h2);
        access(32'h1002, 1'b0);
        chk("R3 abort", {31'h0, abort_o}, 32'h1);
        rd(R_FST, v); chk("R3 fault status", v, 32'h1);
        rd(R_FAD, v); chk("R3 fault address", v, 32'h1002);
        @(negedge clk);
        chk("R10 pulse drops", {31'h0, abort_o}, 32'h0);
        access(32'h1004, 1'b1);
        chk("R3 aligned no abort", {31'h0, abort_o}, 32'h0);
        wr(R_SYS, 32'h0);
        access(32'h1006, 1'b1);
        chk("R3 disabled no abort", {31'h0, abort_o}, 32'h0);
        rd(R_FAD, v); chk("R3 disabled address kept", v, 32'h1002);
        wr(R_PID, 32'h0A00_0000);
        wr(R_SYS, 32'h2);
        access(32'h2001, 1'b0);
        rd(R_FAD, v); chk("R2 relocated fault address", v, 32'h0A00_2001);
        wr(R_SYS, 32'h0);
        wr(R_PID, 32'h0);

        // R7 entry code
        wr(R_BA0, 32'h4000);
        wr(R_CTL, 32'h2);
        access(32'h4000, 1'b0);
        chk("R7 bkpt debug off", {31'h0, bkpt_o}, 32'h1);
        rd(R_DST, v); chk("R7 status untouched", v, 32'h0);
        wr(R_DST, 32'h8000_0000);
        access(32'h4001, 1'b1);
        chk("R7 bkpt debug on", {31'h0, bkpt_o}, 32'h1);
        rd(R_DST, v); chk("R7 entry code", v, 32'h8000_0008);
        @(negedge clk);
        chk("R10 bkpt drops", {31'h0, bkpt_o}, 32'h0);
        wr(R_CTL, 32'h0);

        // R8 external faults
        wr(R_DST, 32'h0);
        ext_fault(32'hFFFF_0555, 32'hDEAD_0000);
        rd(R_FST, v); chk("R8 gated status", v, 32'h1);
        rd(R_FAD, v); chk("R8 gated address", v, 32'h0A00_2001);
        wr(R_DST, 32'h8000_0000);
        ext_fault(32'hFFFF_0555, 32'hDEAD_0000);
        rd(R_FST, v); chk("R8 status loaded", v, 32'h0000_0455);
        rd(R_FAD, v); chk("R8 address loaded", v, 32'hDEAD_0000);

        // R9 write masks
        wr(R_CTL, 32'hFFFF_FFFF); rd(R_CTL, v); chk("R9 control mask", v, 32'h0000_010F);
        wr(R_CTL, 32'h0);
        wr(R_DST, 32'hFFFF_FFFF); rd(R_DST, v); chk("R9 debug mask", v, 32'h8000_001C);
        wr(R_FST, 32'hFFFF_FFFF); rd(R_FST, v); chk("R9 fault status mask", v, 32'h0000_06FF);
        wr(R_SYS, 32'hFFFF_FFFF); rd(R_SYS, v); chk("R9 sysctl mask", v, 32'h0000_0002);
        wr(R_BA1, 32'hFFFF_FFFF); rd(R_BA1, v); chk("R9 full register", v, 32'hFFFF_FFFF);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule